// File: doc/BRIEF.md
# Per-Timeslot CAS Change Detector

This block sits on one TDM port and watches the channel-associated signaling (CAS) nibbles that arrive one timeslot at a time. For every timeslot it keeps the most recently received nibble. When a new nibble differs from the held one, it sets a sticky change flag for that timeslot. A mask register gates the flags into one registered interrupt. For every accepted beat the block also emits the outgoing CAS nibble for that timeslot. A single source-select pin decides whether this nibble is the received value or an entry from a software table that the CPU loads, for example with conditioning values during configuration.

A two-bit mode pin sets the timeslot-validity rules and the nibble format. In the E1 mode, timeslots 0 and 16 are ignored. In the two T1 modes, timeslots 24 to 31 are ignored. In the T1 superframe mode the nibble carries its A and B bits twice, as A,B,A,B, and only the upper pair is significant. The first capture of each timeslot after reset, or after any change of mode, only sets a baseline.

Both streams use valid/ready. A beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained (`!out_valid || out_ready`). While `out_valid` is high and `out_ready` is low, the output beat holds unchanged and no new input is taken. The CPU port is a plain write strobe with a combinational read.

Top module: `cas_change_det`

## Requirements
- R1: After reset, `out_valid` and `irq_o` are 0, `in_ready` is 1, and every change flag, mask bit and software-table entry reads as 0.
- R2: When `mode_i`=00 (E1), timeslots 0 and 16 are ignored and all other timeslots are valid.
- R3: When `mode_i`=01 or 11 (T1) or `mode_i`=10 (T1 superframe), timeslots 0 to 23 are valid and timeslots 24 to 31 are ignored.
- R4: The first accepted nibble of a valid timeslot after reset, or after a mode change, is stored without setting that timeslot's flag.
- R5: Once a timeslot has a baseline, an accepted nibble that differs from the held nibble sets that timeslot's flag on the same edge. An equal nibble leaves the flag unchanged. A set flag stays set until the CPU clears it.
- R6: Writing to address 0x4 clears each flag whose data bit is 1 (bit n is timeslot n). A change that arrives in the same cycle as the clear keeps that flag set.
- R7: `irq_o` is the registered OR over the valid timeslots of (flag AND NOT mask), so it follows a flag or mask update by one cycle. The mask is at address 0x5, bit n for timeslot n. Masking never alters the flag read back from address 0x4.
- R8: In T1 superframe mode only `in_cas[3:2]` (A,B) is compared and stored. The outgoing received-path nibble is {A,B,A,B}.
- R9: When `src_sw_i`=1, `out_cas` is the software-table nibble of `in_ts`. When `src_sw_i`=0, it is the received nibble, reformatted as in R8.
- R10: Software-table row r (0 to 3) is at address r. Timeslot 8r+k sits in data bits [4k+3:4k]. Table entries of ignored timeslots read as 0 but are kept.
- R11: `in_ready` equals `!out_valid || out_ready`. The output beat (`out_ts`, `out_cas`) is stable while `out_valid` is high and `out_ready` is low. It appears one edge after acceptance.
- R12: Beats for ignored timeslots never set a flag and emit `out_cas`=0.
- R13: A change of `mode_i` clears all flags on the next edge, and every timeslot then needs a new baseline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 00 E1, 01/11 T1, 10 T1 superframe |
| src_sw_i | input | 1 | 1 selects the software table as the outgoing CAS source |
| in_valid | input | 1 | Incoming CAS beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_ts | input | 5 | Timeslot of the incoming beat |
| in_cas | input | 4 | Received CAS nibble |
| out_valid | output | 1 | Outgoing CAS beat valid |
| out_ready | input | 1 | Downstream accepts the outgoing beat |
| out_ts | output | 5 | Timeslot of the outgoing beat |
| out_cas | output | 4 | Outgoing CAS nibble |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 4 | CPU address: 0-3 table rows, 4 flags, 5 mask |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data (combinational) |
| irq_o | output | 1 | Masked change interrupt |

## Verification
The bench sends a repeated value after a baseline, and a value that returns to an earlier one. A design that flagged the baseline, or cleared flags on a matching value, would read back the wrong flag bits. It then clears a flag in the same cycle as a fresh change on that timeslot; a design where the clear wins drops the flag. Superframe beats that differ only in the lower copy must raise no flag, and the received-path output must come back replicated. Ignored timeslots 0, 16 and 24 must stay silent with zero output and zero table readback, a mode change must wipe flags and baselines, and a stalled output beat must hold still while input is refused.

// File: rtl/cas_pkg.sv
package cas_pkg;
  typedef enum logic [1:0] {
    MODE_E1   = 2'd0,
    MODE_T1   = 2'd1,
    MODE_T1SF = 2'd2,
    MODE_T1X  = 2'd3
  } cas_mode_e;

  localparam int unsigned CAS_W  = 4;
  localparam int unsigned ROW_TS = 8;
endpackage

// File: rtl/cas_valid_map.sv
module cas_valid_map
  import cas_pkg::*;
#(
  parameter int unsigned NUM_TS = 32
) (
  input  cas_mode_e          mode,
  output logic [NUM_TS-1:0]  valid
);
  for (genvar i = 0; i < NUM_TS; i++) begin : g_ts
    localparam bit E1_OK = (i != 0) && (i != 16);
    localparam bit T1_OK = (i < 24);
    assign valid[i] = (mode == MODE_E1) ? E1_OK : T1_OK;
  end
endmodule

// File: rtl/cas_capture.sv
module cas_capture
  import cas_pkg::*;
#(
  parameter int unsigned NUM_TS = 32,
  localparam int unsigned TS_W  = $clog2(NUM_TS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [TS_W-1:0]   cap_ts,
  input  logic [CAS_W-1:0]  cap_nib,
  input  logic [NUM_TS-1:0] valid,
  input  logic              restart,
  input  logic [NUM_TS-1:0] clr_v,
  output logic [NUM_TS-1:0] flags
);
  logic [CAS_W-1:0]  held [NUM_TS];
  logic [NUM_TS-1:0] seen;
  logic [NUM_TS-1:0] set_v;
  logic              hit;

  always_comb begin
    hit   = cap_en && valid[cap_ts] && !restart;
    set_v = '0;
    if (hit && seen[cap_ts] && (held[cap_ts] != cap_nib))
      set_v[cap_ts] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen  <= '0;
      flags <= '0;
      for (int i = 0; i < NUM_TS; i++) held[i] <= '0;
    end else if (restart) begin
      seen  <= '0;
      flags <= '0;
    end else begin
      flags <= (flags & ~clr_v) | set_v;
      if (hit) begin
        held[cap_ts] <= cap_nib;
        seen[cap_ts] <= 1'b1;
      end
    end
  end

  AST_NO_IGNORED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(valid)) == '0) || $past(restart)); // R12
  AST_BASELINE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(seen)) == '0)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_v & clr_v) != '0) |=> ((flags & $past(set_v & clr_v)) == $past(set_v & clr_v))); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (flags == '0)); // R13
endmodule

// File: rtl/cas_sw_table.sv
module cas_sw_table
  import cas_pkg::*;
#(
  parameter int unsigned NUM_TS = 32,
  localparam int unsigned TS_W   = $clog2(NUM_TS),
  localparam int unsigned ROWS   = NUM_TS / ROW_TS,
  localparam int unsigned RSEL_W = $clog2(ROWS),
  localparam int unsigned LANE_W = $clog2(ROW_TS),
  localparam int unsigned ROW_W  = ROW_TS * CAS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RSEL_W-1:0] wr_row,
  input  logic [ROW_W-1:0]  wdata,
  input  logic [RSEL_W-1:0] rd_row,
  output logic [ROW_W-1:0]  rd_data,
  input  logic [TS_W-1:0]   look_ts,
  output logic [CAS_W-1:0]  look_nib
);
  logic [ROW_W-1:0] rows [ROWS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) rows[r] <= '0;
    end else if (we) begin
      rows[wr_row] <= wdata;
    end
  end

  assign rd_data  = rows[rd_row];
  assign look_nib = rows[look_ts[TS_W-1:LANE_W]][look_ts[LANE_W-1:0]*CAS_W +: CAS_W];
endmodule

// File: rtl/cas_change_det.sv
module cas_change_det
  import cas_pkg::*;
#(
  parameter int unsigned NUM_TS = 32,
  localparam int unsigned TS_W   = $clog2(NUM_TS),
  localparam int unsigned ROWS   = NUM_TS / ROW_TS,
  localparam int unsigned RSEL_W = $clog2(ROWS),
  localparam int unsigned DATA_W = ROW_TS * CAS_W,
  localparam int unsigned AW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              src_sw_i,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TS_W-1:0]   in_ts,
  input  logic [CAS_W-1:0]  in_cas,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TS_W-1:0]   out_ts,
  output logic [CAS_W-1:0]  out_cas,
  input  logic              cpu_we,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq_o
);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(4);
  localparam logic [AW-1:0] MASK_ADDR = AW'(5);

  cas_mode_e         mode_q;
  logic              restart;
  logic [NUM_TS-1:0] valid;
  logic [NUM_TS-1:0] flags;
  logic [NUM_TS-1:0] mask_q;
  logic [NUM_TS-1:0] clr_v;
  logic              accept;
  logic [CAS_W-1:0]  norm_nib;
  logic [CAS_W-1:0]  sw_nib;
  logic [DATA_W-1:0] row_raw;
  logic [DATA_W-1:0] row_vmask;
  logic              tbl_we;
  logic              is_row;

  assign restart  = (mode_i != mode_q);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign norm_nib = (mode_q == MODE_T1SF) ? {in_cas[3:2], in_cas[3:2]} : in_cas;
  assign is_row   = (cpu_addr[AW-1:RSEL_W] == '0);
  assign tbl_we   = cpu_we && is_row;
  assign clr_v    = (cpu_we && cpu_addr == FLAG_ADDR) ? cpu_wdata[NUM_TS-1:0] : '0;

  cas_valid_map #(.NUM_TS(NUM_TS)) u_vmap (
    .mode  (mode_q),
    .valid (valid)
  );

  cas_capture #(.NUM_TS(NUM_TS)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  (accept),
    .cap_ts  (in_ts),
    .cap_nib (norm_nib),
    .valid   (valid),
    .restart (restart),
    .clr_v   (clr_v),
    .flags   (flags)
  );

  cas_sw_table #(.NUM_TS(NUM_TS)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (tbl_we),
    .wr_row   (cpu_addr[RSEL_W-1:0]),
    .wdata    (cpu_wdata),
    .rd_row   (cpu_addr[RSEL_W-1:0]),
    .rd_data  (row_raw),
    .look_ts  (in_ts),
    .look_nib (sw_nib)
  );

  always_comb begin
    for (int k = 0; k < ROW_TS; k++) begin
      logic [TS_W-1:0] idx;
      idx = TS_W'(int'(cpu_addr[RSEL_W-1:0]) * ROW_TS + k);
      row_vmask[k*CAS_W +: CAS_W] = {CAS_W{valid[idx]}};
    end
  end

  always_comb begin
    if (is_row)                      cpu_rdata = row_raw & row_vmask;
    else if (cpu_addr == FLAG_ADDR)  cpu_rdata = DATA_W'(flags);
    else if (cpu_addr == MASK_ADDR)  cpu_rdata = DATA_W'(mask_q);
    else                             cpu_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= MODE_E1;
      mask_q    <= '0;
      irq_o     <= 1'b0;
      out_valid <= 1'b0;
      out_ts    <= '0;
      out_cas   <= '0;
    end else begin
      mode_q <= cas_mode_e'(mode_i);
      irq_o  <= |(flags & ~mask_q & valid);
      if (cpu_we && cpu_addr == MASK_ADDR) mask_q <= cpu_wdata[NUM_TS-1:0];
      if (accept) begin
        out_valid <= 1'b1;
        out_ts    <= in_ts;
        if (!valid[in_ts])  out_cas <= '0;
        else if (src_sw_i)  out_cas <= sw_nib;
        else                out_cas <= norm_nib;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ts) && $stable(out_cas))); // R11
  AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_q) == '1) |-> !irq_o); // R7
  AST_IGNORED_OUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !valid[in_ts]) |=> (out_cas == '0)); // R12
  AST_NO_TAKE_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R11
endmodule

// File: tb/tb_cas_change_det.sv
module tb_cas_change_det;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        src_sw_i = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_ts = '0;
  logic [3:0]  in_cas = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [4:0]  out_ts;
  logic [3:0]  out_cas;
  logic        cpu_we = 1'b0;
  logic [3:0]  cpu_addr = 4'h4;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  cas_change_det dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .src_sw_i(src_sw_i),
    .in_valid(in_valid), .in_ready(in_ready), .in_ts(in_ts), .in_cas(in_cas),
    .out_valid(out_valid), .out_ready(out_ready), .out_ts(out_ts), .out_cas(out_cas),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .irq_o(irq_o)
  );

  // {ts[4:0], cas[3:0], flag_after, out_cas[3:0]} in E1 mode, received source
  localparam logic [13:0] VEC [11] = '{
    {5'd3,  4'hA, 1'b0, 4'hA},
    {5'd3,  4'hA, 1'b0, 4'hA},
    {5'd3,  4'h5, 1'b1, 4'h5},
    {5'd5,  4'h7, 1'b0, 4'h7},
    {5'd5,  4'h7, 1'b0, 4'h7},
    {5'd0,  4'hF, 1'b0, 4'h0},
    {5'd16, 4'hF, 1'b0, 4'h0},
    {5'd0,  4'h1, 1'b0, 4'h0},
    {5'd31, 4'h2, 1'b0, 4'h2},
    {5'd31, 4'h3, 1'b1, 4'h3},
    {5'd5,  4'h6, 1'b1, 4'h6}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] ts, input logic [3:0] cas);
    @(negedge clk);
    in_valid = 1'b1; in_ts = ts; in_cas = cas;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
  endtask

  task automatic cpu_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
    #1;
  endtask

  task automatic cpu_read(input logic [3:0] a, output logic [31:0] d);
    cpu_addr = a;
    #1;
    d = cpu_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    #1;
    chk(irq_o, 0, "R1 irq");
    chk(out_valid, 0, "R1 out_valid");
    chk(in_ready, 1, "R1 in_ready");
    cpu_read(4'h4, rd); chk(rd, 0, "R1 flags");
    cpu_read(4'h5, rd); chk(rd, 0, "R1 mask");
    cpu_read(4'h1, rd); chk(rd, 0, "R1 table");
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 11; i++) begin
      send(VEC[i][13:9], VEC[i][8:5]);
      chk(out_cas, VEC[i][3:0], "R5/R12 out_cas");
      chk(out_ts, VEC[i][13:9], "R11 out_ts");
      cpu_read(4'h4, rd);
      chk(rd[VEC[i][13:9]], VEC[i][4], "R4/R5/R2 flag");
    end

    @(negedge clk); @(negedge clk); #1;
    chk(irq_o, 1, "R7 irq raised");
    cpu_write(4'h5, 32'h8000_0028);
    @(negedge clk); #1;
    chk(irq_o, 0, "R7 irq masked");
    cpu_read(4'h4, rd); chk(rd, 32'h8000_0028, "R7 flags kept under mask");

    // R6: clear bit31 in the same cycle ts31 changes 3 -> 4
    @(negedge clk);
    in_valid = 1'b1; in_ts = 5'd31; in_cas = 4'h4;
    cpu_we = 1'b1; cpu_addr = 4'h4; cpu_wdata = 32'h8000_0000;
    @(negedge clk);
    in_valid = 1'b0; cpu_we = 1'b0; #1;
    cpu_read(4'h4, rd); chk(rd, 32'h8000_0028, "R6 set wins over clear");
    cpu_write(4'h4, 32'h8000_0008);
    cpu_read(4'h4, rd); chk(rd, 32'h0000_0020, "R6 w1c");

    cpu_write(4'h0, 32'h0000_900F);
    cpu_read(4'h0, rd); chk(rd, 32'h0000_9000, "R10 row0 ts0 ignored reads zero");
    src_sw_i = 1'b1;
    send(5'd3, 4'h1);
    chk(out_cas, 4'h9, "R9 software source");
    src_sw_i = 1'b0;
    send(5'd3, 4'h2);
    chk(out_cas, 4'h2, "R9 received source");
    cpu_write(4'h2, 32'hFFFF_FFFF);
    cpu_read(4'h2, rd); chk(rd, 32'hFFFF_FFF0, "R2 ts16 ignored in E1");

    // switch to T1 superframe
    @(negedge clk); mode_i = 2'd2;
    @(negedge clk); #1;
    cpu_read(4'h4, rd); chk(rd, 0, "R13 flags cleared on mode change");
    cpu_read(4'h2, rd); chk(rd, 32'hFFFF_FFFF, "R3 ts16 valid in T1");
    cpu_write(4'h3, 32'hFFFF_FFFF);
    cpu_read(4'h3, rd); chk(rd, 0, "R3 ts24-31 ignored in T1");
    send(5'd24, 4'hF);
    chk(out_cas, 4'h0, "R12 ignored ts24 out zero");
    cpu_read(4'h4, rd); chk(rd, 0, "R12 ignored ts24 no flag");
    send(5'd3, 4'h5);
    cpu_read(4'h4, rd); chk(rd[3], 0, "R4 baseline after mode change");
    chk(out_cas, 4'h5, "R8 replicated 01");
    send(5'd2, 4'b1000);
    chk(out_cas, 4'b1010, "R8 replicated 10");
    send(5'd2, 4'b1011);
    chk(out_cas, 4'b1010, "R8 lower copy ignored");
    cpu_read(4'h4, rd); chk(rd[2], 0, "R8 no flag on lower copy");
    send(5'd2, 4'b0100);
    chk(out_cas, 4'b0101, "R8 new AB");
    cpu_read(4'h4, rd); chk(rd[2], 1, "R5 flag on AB change");
    @(negedge clk); @(negedge clk); #1;
    chk(irq_o, 1, "R7 unmasked bit2 raises irq");

    // R11 back-pressure
    out_ready = 1'b0;
    send(5'd5, 4'b1100);
    chk(out_valid, 1, "R11 out_valid");
    chk(in_ready, 0, "R11 in_ready low when stalled");
    @(negedge clk); #1;
    chk(out_cas, 4'b1111, "R11 held out_cas");
    chk(out_ts, 5'd5, "R11 held out_ts");
    out_ready = 1'b1;
    @(negedge clk); #1;
    chk(out_valid, 0, "R11 drained");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule